// File: doc/BRIEF.md
# Hamming Single-Error-Correcting Memory Interface

This block sits between an 8-bit processor data path and a memory that stores 12 bits per location. On a write it computes four Hamming parity bits for the byte and sends the 12-bit code word to the memory. On a read it recomputes the parity over the returned word and forms a 4-bit syndrome. When that syndrome points at a real bit position, the block inverts that one bit. It then hands the repaired byte to the processor, with a one-cycle valid pulse, one clock after the read strobe.

A repair is never written back. The stored word stays damaged until the processor next writes that location, and every later read repairs it again. Each repair adds one to a saturating 16-bit upset counter, which the processor can clear synchronously. Words with more than one bit in error are not flagged: the syndrome rule alone decides what is returned. The memory is an external synchronous array whose read data appears one clock after its read enable.

Top module: `hamming_edac_if`

## Requirements
- R1: On a write, `mem_wdata` carries the code word with bit i holding code position i+1. Parity sits at positions 1, 2, 4 and 8. The data bits d0..d7 go, in order, to positions 3, 5, 6, 7, 9, 10, 11 and 12. Parity bit 2^k makes even the XOR of all positions whose index has bit k set. Example: byte 8'hFF is stored as 12'hF77 and byte 8'h01 as 12'h007.
- R2: Reading an undamaged word returns the byte that was written and leaves the counter unchanged.
- R3: Reading a word with exactly one inverted bit, at any of the 12 positions, returns the original byte. The counter rises by one on the clock edge after the valid pulse.
- R4: `cpu_rvalid` is high for exactly the cycle after each clock edge at which a read was accepted (`cpu_rd` high, `cpu_wr` low), and low otherwise. `cpu_rdata` is valid while it is high.
- R5: `mem_we` is high only when `cpu_wr` is high, so a read never writes to memory. A damaged word is repaired, and counted, again on every read until the location is rewritten.
- R6: A syndrome of 13, 14 or 15 inverts no bit and leaves the counter unchanged. The data bits are returned exactly as stored, and no error indication exists.
- R7: A two-bit error whose syndrome falls in 1..12 is treated as a single error at the position the syndrome names, and it is counted.
- R8: The counter saturates at 16'hFFFF and holds there while further repairs occur.
- R9: `cnt_clr` sets the counter to zero at the next clock edge and takes priority over an increment at that same edge.
- R10: When `cpu_wr` and `cpu_rd` are high together, the write is performed and no read is started: there is no valid pulse.
- R11: While reset is asserted, `cpu_rvalid` is low and the counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Write strobe from the processor |
| cpu_rd | input | 1 | Read strobe from the processor |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | 8 | Byte to write |
| cpu_rdata | output | 8 | Repaired read byte |
| cpu_rvalid | output | 1 | Read data valid, one clock after the strobe |
| cnt_clr | input | 1 | Synchronous clear of the upset counter |
| upset_cnt | output | CNT_W | Saturating count of repaired words |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 12 | Code word to store |
| mem_rdata | input | 12 | Code word read back, one clock after `mem_re` |

## Verification
Some properties are checked on every cycle. Each stored code word must have a zero syndrome, computed with masks written independently of the design. The memory must never be written without a processor write. The valid pulse must follow an accepted read by one cycle. The counter may change only after a valid pulse or a clear, by at most one step, and must hold at saturation. Other behaviour can only be shown by the bench scenarios: the value of each repaired byte, the position mapping of the code, the different outcomes of syndromes 13 to 15 and of miscorrected double errors, repeated repair of an unrewritten word, and a clear that collides with an increment after saturation.

// File: rtl/edac_pkg.sv
package edac_pkg;
  localparam int DATA_W = 8;
  localparam int CHK_W  = 4;
  localparam int CODE_W = DATA_W + CHK_W;

  // Scatter data bits into the non-power-of-two code positions (1-based).
  function automatic logic [CODE_W-1:0] place_data(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] w;
    int j;
    w = '0;
    j = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        w[p-1] = d[j];
        j++;
      end
    end
    return w;
  endfunction

  // Gather data bits back out of a code word.
  function automatic logic [DATA_W-1:0] gather_data(input logic [CODE_W-1:0] w);
    logic [DATA_W-1:0] d;
    int j;
    d = '0;
    j = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[j] = w[p-1];
        j++;
      end
    end
    return d;
  endfunction

  // Positions covered by parity bit 2**k.
  function automatic logic [CODE_W-1:0] cover_mask(input int k);
    logic [CODE_W-1:0] m;
    m = '0;
    for (int p = 1; p <= CODE_W; p++) begin
      m[p-1] = ((p >> k) & 1) != 0;
    end
    return m;
  endfunction
endpackage

// File: rtl/hamm_enc.sv
module hamm_enc
  import edac_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] spread;

  always_comb begin
    spread = place_data(data_i);
    code_o = spread;
    for (int k = 0; k < CHK_W; k++) begin
      code_o[(1 << k) - 1] = ^(spread & cover_mask(k));
    end
  end
endmodule

// File: rtl/hamm_dec.sv
module hamm_dec
  import edac_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [DATA_W-1:0] data_o,
  output logic              fixed_o
);
  logic [CHK_W-1:0]  syn;
  logic [CODE_W-1:0] flip;
  logic [CODE_W-1:0] repaired;

  always_comb begin
    for (int k = 0; k < CHK_W; k++) begin
      syn[k] = ^(code_i & cover_mask(k));
    end
    fixed_o = (syn != '0) && (int'(syn) <= CODE_W);
    flip = '0;
    if (fixed_o) begin
      flip = CODE_W'(1) << (syn - CHK_W'(1));
    end
    repaired = code_i ^ flip;
    data_o = gather_data(repaired);
  end
endmodule

// File: rtl/upset_ctr.sv
module upset_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i || (inc_i && (cnt_q != TOP));
    cnt_d  = clr_i ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/hamming_edac_if.sv
module hamming_edac_if
  import edac_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rvalid,
  input  logic              cnt_clr,
  output logic [CNT_W-1:0]  upset_cnt,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CODE_W-1:0] mem_wdata,
  input  logic [CODE_W-1:0] mem_rdata
);
  logic rd_take;
  logic rvalid_q, rvalid_d;
  logic fixed;

  // Write wins over a simultaneous read.
  assign rd_take  = cpu_rd && !cpu_wr;
  assign mem_we   = cpu_wr;
  assign mem_re   = rd_take;
  assign mem_addr = cpu_addr;

  hamm_enc enc_i (
    .data_i (cpu_wdata),
    .code_o (mem_wdata)
  );

  hamm_dec dec_i (
    .code_i  (mem_rdata),
    .data_o  (cpu_rdata),
    .fixed_o (fixed)
  );

  always_comb rvalid_d = rd_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else rvalid_q <= rvalid_d;
  end

  assign cpu_rvalid = rvalid_q;

  upset_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr),
    .inc_i (rvalid_q && fixed),
    .cnt_o (upset_cnt)
  );
endmodule

// File: rtl/edac_chk.sv
module edac_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic              cpu_rvalid,
  input logic              cnt_clr,
  input logic [CNT_W-1:0]  upset_cnt,
  input logic              mem_we,
  input logic [11:0]       mem_wdata
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  // R1
  code_zero_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (^(mem_wdata & 12'h555) == 1'b0) && (^(mem_wdata & 12'h666) == 1'b0) &&
               (^(mem_wdata & 12'h878) == 1'b0) && (^(mem_wdata & 12'hF80) == 1'b0));

  // R5
  no_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> cpu_wr);

  // R4
  rvalid_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr) |=> cpu_rvalid);

  // R10
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rd && !cpu_wr) |=> !cpu_rvalid);

  // R3
  cnt_only_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && !cpu_rvalid) |=> $stable(upset_cnt));

  // R3
  cnt_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (upset_cnt == $past(upset_cnt)) || (upset_cnt == $past(upset_cnt) + 1'b1));

  // R8
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upset_cnt == FULL && !cnt_clr) |=> upset_cnt == FULL);

  // R9
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> upset_cnt == '0);
endmodule

bind hamming_edac_if edac_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_wr     (cpu_wr),
  .cpu_rd     (cpu_rd),
  .cpu_rvalid (cpu_rvalid),
  .cnt_clr    (cnt_clr),
  .upset_cnt  (upset_cnt),
  .mem_we     (mem_we),
  .mem_wdata  (mem_wdata)
);

// File: tb/hamming_edac_if_tb_top.sv
module hamming_edac_if_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cpu_wr, cpu_rd, cnt_clr;
  logic [7:0]  cpu_addr;
  logic [7:0]  cpu_wdata;
  logic [7:0]  cpu_rdata;
  logic        cpu_rvalid;
  logic [15:0] upset_cnt;
  logic        mem_we, mem_re;
  logic [7:0]  mem_addr;
  logic [11:0] mem_wdata;
  logic [11:0] mem_rdata;

  hamming_edac_if dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_rvalid(cpu_rvalid), .cnt_clr(cnt_clr), .upset_cnt(upset_cnt),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Synchronous memory model: read data one clock after the enable.
  logic [11:0] ram [0:255];
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr];
  end

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model
  typedef struct {
    logic [7:0] d;
    bit         inc;
    string      tag;
  } exp_t;
  exp_t exp_q[$];
  bit          pend_inc = 1'b0;
  bit          model_rv;
  logic [15:0] model_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_rv  <= 1'b0;
      model_cnt <= 16'h0;
    end else begin
      model_rv <= cpu_rd && !cpu_wr;
      if (cnt_clr) model_cnt <= 16'h0;
      else if (pend_inc && model_cnt != 16'hFFFF) model_cnt <= model_cnt + 16'h1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(cpu_rvalid == model_rv, "R4 rvalid", {31'b0, cpu_rvalid}, {31'b0, model_rv});
      check(upset_cnt == model_cnt, "R3 counter", {16'b0, upset_cnt}, {16'b0, model_cnt});
      check(mem_we == cpu_wr, "R5 mem_we", {31'b0, mem_we}, {31'b0, cpu_wr});
      pend_inc = 1'b0;
      if (cpu_rvalid && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(cpu_rdata == e.d, e.tag, {24'b0, cpu_rdata}, {24'b0, e.d});
        pend_inc = e.inc;
      end
    end
  end

  task automatic idle();
    cpu_wr = 1'b0; cpu_rd = 1'b0; cnt_clr = 1'b0;
  endtask

  task automatic write(input logic [7:0] a, input logic [7:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic read(input logic [7:0] a, input logic [7:0] d, input bit inc, input string tag);
    exp_t e;
    e.d = d; e.inc = inc; e.tag = tag;
    exp_q.push_back(e);
    cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk);
    idle();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R4 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cpu_addr = 8'h0; cpu_wdata = 8'h0;
    idle();
    for (int i = 0; i < 256; i++) ram[i] = 12'h0;
    repeat (3) @(negedge clk);
    // R11
    check(cpu_rvalid == 1'b0, "R11 rvalid in reset", {31'b0, cpu_rvalid}, 0);
    check(upset_cnt == 16'h0, "R11 count in reset", {16'b0, upset_cnt}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: code word layout
    cpu_wr = 1'b1; cpu_addr = 8'd1; cpu_wdata = 8'hFF;
    #1 check(mem_wdata == 12'hF77, "R1 code of FF", {20'b0, mem_wdata}, 32'hF77);
    @(negedge clk);
    cpu_addr = 8'd2; cpu_wdata = 8'h01;
    #1 check(mem_wdata == 12'h007, "R1 code of 01", {20'b0, mem_wdata}, 32'h007);
    @(negedge clk);
    idle();

    // R2: clean reads over several patterns
    for (int i = 0; i < 16; i++) write(8'(10 + i), 8'(i * 37 + 5));
    for (int i = 0; i < 16; i++) read(8'(10 + i), 8'(i * 37 + 5), 1'b0, "R2 clean read");
    read(8'd1, 8'hFF, 1'b0, "R2 clean FF");

    // R3: one inverted bit at every position
    for (int p = 0; p < 12; p++) write(8'(40 + p), 8'hA5 ^ 8'(p * 17));
    for (int p = 0; p < 12; p++) ram[40 + p] = ram[40 + p] ^ (12'h1 << p);
    for (int p = 0; p < 12; p++) read(8'(40 + p), 8'hA5 ^ 8'(p * 17), 1'b1, "R3 single repair");

    // R5: stored word stays damaged until rewritten
    read(8'd40, 8'hA5, 1'b1, "R5 repeat repair");
    write(8'd40, 8'h5C);
    read(8'd40, 8'h5C, 1'b0, "R5 after rewrite");

    // R6: syndromes 13, 14, 15
    write(8'd60, 8'h3C); write(8'd61, 8'h3C); write(8'd62, 8'h3C);
    ram[60] = ram[60] ^ 12'h108;
    ram[61] = ram[61] ^ 12'h802;
    ram[62] = ram[62] ^ 12'h804;
    read(8'd60, 8'h3C ^ 8'h10, 1'b0, "R6 syndrome 13");
    read(8'd61, 8'h3C ^ 8'h80, 1'b0, "R6 syndrome 14");
    read(8'd62, 8'h3C ^ 8'h81, 1'b0, "R6 syndrome 15");

    // R7: double error miscorrected at position 6
    write(8'd63, 8'hC3);
    ram[63] = ram[63] ^ 12'h014;
    read(8'd63, 8'hC3 ^ 8'h07, 1'b1, "R7 miscorrection");

    // R10: write and read together
    cpu_wr = 1'b1; cpu_rd = 1'b1; cpu_addr = 8'd70; cpu_wdata = 8'h5A;
    @(negedge clk);
    idle();
    @(negedge clk);
    read(8'd70, 8'h5A, 1'b0, "R10 write took effect");

    // R9: clear alone
    cnt_clr = 1'b1;
    @(negedge clk);
    idle();
    check(upset_cnt == 16'h0, "R9 clear", {16'b0, upset_cnt}, 0);

    // R8: stream reads of a damaged word past saturation
    for (int i = 0; i < 65540; i++) begin
      exp_t e;
      e.d = 8'hA5 ^ 8'd17; e.inc = 1'b1; e.tag = "R8 stream repair";
      exp_q.push_back(e);
      cpu_rd = 1'b1; cpu_addr = 8'd41;
      @(negedge clk);
    end
    check(upset_cnt == 16'hFFFF, "R8 saturated", {16'b0, upset_cnt}, 32'hFFFF);
    // R9: clear collides with the last pending increment
    cpu_rd = 1'b0; cnt_clr = 1'b1;
    @(negedge clk);
    idle();
    check(upset_cnt == 16'h0, "R9 clear beats increment", {16'b0, upset_cnt}, 0);
    @(negedge clk);
    check(upset_cnt == 16'h0, "R9 stays cleared", {16'b0, upset_cnt}, 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule